// File: doc/BRIEF.md
# Serial Receive Port with Byte-Ready Flag

This block is the receive half of a serial peripheral slave that hangs off a simple memory-mapped processor bus. The serial clock, chip select and data-in pins are brought through flip-flop chains into a much faster internal clock, and every piece of logic runs on that clock. The serial clock only toggles during a transfer, so it is never used as a clock itself. Bits are taken on the rising edge of the synchronised serial clock while select is low, most significant bit first. Each complete byte is copied into a holding register and raises a byte-ready flag.

The processor drains bytes by reading the data address. The decoded read is registered into a one-cycle pulse. That pulse moves the held byte onto the bus and clears the flag in the same edge. Set and clear live in one clocked process, and set has priority. As a result, a byte that lands in the same cycle as a read is kept, flagged as unread, and not counted as an overrun. The overrun flag is raised only when an unread byte is really overwritten. It is cleared by reading the status address.

Top module: `spi_rx_port`

## Requirements
- R1: After synchronous reset, rx_ready, rx_overrun, bus_rvalid and bus_rdata are all 0.
- R2: While spi_cs_n is low, spi_mosi is taken on each rising edge of spi_sclk, most significant bit first, and every 8 such edges deliver one byte to the data register.
- R3: A high level on spi_cs_n discards any partial byte and restarts the bit count, so the next byte starts at its first bit.
- R4: Loading a byte into the data register sets rx_ready.
- R5: A bus_rd strobe with bus_addr = 0 (data address) sampled at clock edge E clears rx_ready at edge E+1. At that same edge it drives the held byte onto bus_rdata with bus_rvalid high for one cycle.
- R6: When a byte is loaded in the same edge that a data read clears the flag, rx_ready stays 1, and that read returns the previous byte.
- R7: rx_overrun becomes 1 when a byte is loaded while rx_ready is 1 and no data read acts in that edge. It stays 0 when the load coincides with a data read.
- R8: A bus_rd strobe with bus_addr = 1 (status address) returns bit 0 = rx_ready and bit 1 = rx_overrun, with the upper bits 0, in the R5 timing. It clears rx_overrun and leaves rx_ready unchanged.
- R9: A rising spi_sclk edge that completes a byte, applied before clock edge k, loads the data register at clock edge k+3 (two synchroniser stages plus edge detection).
- R10: A bus read of any other address returns 0 with bus_rvalid and changes neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, much faster than spi_sclk |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock pin, asynchronous |
| spi_cs_n | input | 1 | Chip select pin, active low, asynchronous |
| spi_mosi | input | 1 | Serial data in pin, asynchronous |
| bus_rd | input | 1 | One-cycle bus read strobe |
| bus_addr | input | ADDR_W | Bus read address |
| bus_rdata | output | BYTE_W | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle per read |
| rx_ready | output | 1 | Byte-ready flag |
| rx_overrun | output | 1 | Overrun flag |

## Verification
The bench builds the default configuration: 8-bit bytes, two synchroniser stages and a 2-bit address. With 8-bit bytes it is practical to send all 256 byte values and read each one back. The short synchroniser chain fixes the load edge exactly, so the bench can sweep the data read through every cycle offset from three before to three after the load edge. That sweep reaches the coincident set-and-clear case and both sides of the overrun boundary. Partial bytes broken by select, status reads and reads of an unused address are checked separately.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  // Kind of bus access latched into the one-cycle read pulse
  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_DATA  = 2'd1,
    RD_STAT  = 2'd2,
    RD_OTHER = 2'd3
  } rd_kind_t;
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= RST_VAL;
        else     stage_q[0] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RST_VAL;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic              sclk_prev;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] shreg;
  logic              sclk_rise;

  assign sclk_rise = sclk_s & ~sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_done <= 1'b0;
      byte_val  <= '0;
    end else begin
      sclk_prev <= sclk_s;
      byte_done <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[BYTE_W-3:0], mosi_s};
        if (bit_cnt == LAST) begin
          bit_cnt   <= '0;
          byte_done <= 1'b1;
          byte_val  <= {shreg, mosi_s};
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // A byte needs several serial edges, so completion never repeats back to back
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> !byte_done); // R2
endmodule

// File: rtl/spi_rx_regs.sv
module spi_rx_regs
  import spi_rx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] DATA_ADDR = '0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              rxne,
  output logic              ovr
);
  rd_kind_t          rd_dec, rd_q;
  logic [BYTE_W-1:0] rx_data_q;
  logic [BYTE_W-1:0] stat_word;
  logic              rd_data_pulse;

  always_comb begin
    if (!bus_rd)                 rd_dec = RD_NONE;
    else if (bus_addr == DATA_ADDR) rd_dec = RD_DATA;
    else if (bus_addr == STAT_ADDR) rd_dec = RD_STAT;
    else                         rd_dec = RD_OTHER;
  end

  assign rd_data_pulse = (rd_q == RD_DATA);

  always_comb begin
    stat_word    = '0;
    stat_word[0] = rxne;
    stat_word[1] = ovr;
  end

  // Registered read pulse, one cycle per strobe
  always_ff @(posedge clk) begin
    if (rst) rd_q <= RD_NONE;
    else     rd_q <= rd_dec;
  end

  // Flags: set has priority over clear
  always_ff @(posedge clk) begin
    if (rst) begin
      rxne      <= 1'b0;
      ovr       <= 1'b0;
      rx_data_q <= '0;
    end else begin
      if (byte_done)          rxne <= 1'b1;
      else if (rd_data_pulse) rxne <= 1'b0;

      if (byte_done && rxne && !rd_data_pulse) ovr <= 1'b1;
      else if (rd_q == RD_STAT)                ovr <= 1'b0;

      if (byte_done) rx_data_q <= byte_val;
    end
  end

  // Bus return path
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= (rd_q != RD_NONE);
      case (rd_q)
        RD_DATA:  bus_rdata <= rx_data_q;
        RD_STAT:  bus_rdata <= stat_word;
        RD_OTHER: bus_rdata <= '0;
        default:  bus_rdata <= bus_rdata;
      endcase
    end
  end

  AST_LOAD_SETS: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> rxne); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (byte_done && rd_data_pulse) |=> (rxne && !$past(ovr) == !ovr)); // R6
  AST_DATA_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_data_pulse && !byte_done) |=> !rxne); // R5
  AST_OVR_ON_UNREAD: assert property (@(posedge clk) disable iff (rst)
    (byte_done && rxne && !rd_data_pulse) |=> ovr); // R7
  AST_NO_FALSE_OVR: assert property (@(posedge clk) disable iff (rst)
    (!ovr && !(byte_done && rxne && !rd_data_pulse)) |=> !ovr); // R7
  AST_STAT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (rd_q == RD_STAT && rxne) |=> rxne); // R8
endmodule

// File: rtl/spi_rx_port.sv
module spi_rx_port
  import spi_rx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] DATA_ADDR = '0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              rx_ready,
  output logic              rx_overrun
);
  localparam int PINS = 3;
  localparam logic [PINS-1:0] PIN_RST = 3'b010; // {sclk, cs_n, mosi}

  logic [PINS-1:0]   pins_s;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_val;

  spi_rx_sync #(
    .WIDTH  (PINS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_RST)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .d_in ({spi_sclk, spi_cs_n, spi_mosi}),
    .d_out(pins_s)
  );

  spi_rx_shifter #(
    .BYTE_W(BYTE_W)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (pins_s[2]),
    .cs_n_s   (pins_s[1]),
    .mosi_s   (pins_s[0]),
    .byte_done(byte_done),
    .byte_val (byte_val)
  );

  spi_rx_regs #(
    .BYTE_W   (BYTE_W),
    .ADDR_W   (ADDR_W),
    .DATA_ADDR(DATA_ADDR),
    .STAT_ADDR(STAT_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .byte_done (byte_done),
    .byte_val  (byte_val),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid),
    .rxne      (rx_ready),
    .ovr       (rx_overrun)
  );
endmodule

// File: tb/sim_spi_rx_port.sv
`timescale 1ns/1ps
module sim_spi_rx_port;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       spi_sclk = 1'b0;
  logic       spi_cs_n = 1'b1;
  logic       spi_mosi = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;
  logic       rx_ready;
  logic       rx_overrun;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_rx_port u0 (
    .clk(clk), .rst(rst),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .rx_ready(rx_ready), .rx_overrun(rx_overrun)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    spi_mosi = b;
    spi_sclk = 1'b0;
    tick(HALF);
    spi_sclk = 1'b1;
    tick(HALF);
    spi_sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    tick(HALF);
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_rd = 1'b1;
    bus_addr = a;
    tick(1);
    bus_rd = 1'b0;
    tick(1);
    chk("R5 rvalid high", bus_rvalid, 1);
    d = bus_rdata;
    tick(1);
    chk("R5 rvalid one cycle", bus_rvalid, 0);
  endtask

  initial begin
    logic [7:0] d;
    tick(4);
    rst = 1'b0;
    tick(1);
    chk("R1 ready", rx_ready, 0);
    chk("R1 overrun", rx_overrun, 0);
    chk("R1 rvalid", bus_rvalid, 0);
    chk("R1 rdata", bus_rdata, 0);

    // R2 R4 R5: every byte value
    for (int v = 0; v < 256; v++) begin
      spi_cs_n = 1'b0;
      tick(2);
      send_byte(8'(v));
      chk("R4 ready after byte", rx_ready, 1);
      bus_read(2'd0, d);
      chk("R2 byte value", d, 32'(v));
      chk("R5 ready cleared", rx_ready, 0);
      chk("R7 no overrun", rx_overrun, 0);
      spi_cs_n = 1'b1;
      tick(3);
    end

    // R3: partial byte dropped by select going high
    spi_cs_n = 1'b0;
    tick(2);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    spi_cs_n = 1'b1;
    tick(4);
    chk("R3 no partial byte", rx_ready, 0);
    spi_cs_n = 1'b0;
    tick(2);
    send_byte(8'hA5);
    bus_read(2'd0, d);
    chk("R3 realigned byte", d, 32'hA5);
    chk("R3 single byte", rx_ready, 0);

    // R8 R10: status and unused address
    send_byte(8'h3C);
    bus_read(2'd1, d);
    chk("R8 status word", d, 32'h01);
    chk("R8 ready kept", rx_ready, 1);
    bus_read(2'd2, d);
    chk("R10 other reads zero", d, 0);
    chk("R10 ready kept", rx_ready, 1);
    chk("R10 overrun kept", rx_overrun, 0);
    bus_read(2'd0, d);
    chk("R8 data after status", d, 32'h3C);

    // R6 R7 R9: sweep data read around the load edge
    for (int dd = -3; dd <= 3; dd++) begin
      logic [7:0] a_val, b_val, got;
      a_val = 8'(8'h50 + dd);
      b_val = 8'(8'hC0 ^ dd);
      got = 8'h00;
      send_byte(a_val);
      for (int i = 7; i >= 1; i--) send_bit(b_val[i]);
      spi_mosi = b_val[0];
      tick(HALF);
      for (int i = -1; i <= 8; i++) begin
        if (bus_rvalid) got = bus_rdata;
        if (i == 0) spi_sclk = 1'b1;
        bus_rd = (i == 2 + dd);
        bus_addr = 2'd0;
        tick(1);
      end
      bus_rd = 1'b0;
      spi_sclk = 1'b0;
      tick(HALF);
      if (dd <= 0) begin
        chk("R6 read returns older byte", got, 32'(a_val));
        chk("R6 ready stays set", rx_ready, 1);
        chk("R7 no false overrun", rx_overrun, 0);
        bus_read(2'd1, d);
        chk("R8 status after sweep", d, 32'h01);
        bus_read(2'd0, d);
        chk("R9 newer byte kept", d, 32'(b_val));
      end else begin
        chk("R7 late read gets newer byte", got, 32'(b_val));
        chk("R7 ready cleared", rx_ready, 0);
        chk("R7 overrun raised", rx_overrun, 1);
        bus_read(2'd1, d);
        chk("R8 status shows overrun", d, 32'h02);
        chk("R8 overrun cleared", rx_overrun, 0);
      end
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule